// File: doc/BRIEF.md
# Write-Only Two-Wire Control Slave

This block is a slave on a two-wire serial control bus. It accepts one kind of transaction only: a write that carries a single 16-bit control word. The bus clock and data lines are brought into the system clock domain through synchronisers and oversampled there. The block never drives the data line high. Its only output toward the bus is an active-high enable that pulls the data line low during acknowledge bits.

A transaction begins with a start condition. A byte follows that holds a 7-bit device address and a direction bit. When the address equals `dev_addr` and the direction bit marks a write, the slave acknowledges. It then takes two payload bytes and acknowledges each one. The first byte holds a 7-bit register address in its upper seven bits, and its lowest bit is the most significant of nine data bits. The second byte holds the other eight data bits. When the last acknowledge ends, the block issues a one-cycle register write.

Read requests, a mismatched address, or a start or stop seen in the middle of a transfer all leave the slave idle and silent. It then waits for a fresh start.

Top module: `ctl2w_write_slave`

## Requirements
- R1: While reset is active, `sda_pull` and `wr_en` are low.
- R2: A start is a falling data line while the clock line is high. After a start, eight bits are sampled on clock rising edges, most significant bit first. The upper seven bits are the device address and bit 0 is the direction bit.
- R3: When the device address equals `dev_addr` and the direction bit is 0, `sda_pull` is asserted after the clock falls that ends bit 8. It stays high through the ninth clock pulse and is released after that pulse falls.
- R4: When the device address differs from `dev_addr`, there is no acknowledge and no write. Later bytes in the same transfer are not acknowledged.
- R5: When the direction bit is 1, there is no acknowledge and no write, even if the address matches.
- R6: Each of the two payload bytes that follow an acknowledged address is itself acknowledged, with the same timing as R3.
- R7: After the clock falls that ends the second payload acknowledge, `wr_en` is high for exactly one cycle. At that point `wr_addr` equals payload byte 1 bits 7..1, and `wr_data` equals payload byte 1 bit 0 followed by payload byte 2 bits 7..0. The pulse does not wait for a stop.
- R8: A start or a stop (data line rising while the clock line is high) seen after the address phase has begun returns the slave to idle, with no write. A start seen there is not taken as the start of a new transfer, so the address byte that follows it is not acknowledged.
- R9: After a completed write and a stop, the next transfer is decoded normally. A change of `dev_addr` between transfers takes effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous |
| dev_addr | input | 7 | Own device address |
| sda_pull | output | 1 | High pulls the data line low (acknowledge) |
| wr_en | output | 1 | One-cycle register write strobe |
| wr_addr | output | 7 | Register address of the write |
| wr_data | output | 9 | Register data of the write |

## Verification
The bench probes the direction bit and the device address on their own. A slave that ignored bit 0 would acknowledge reads, and one that compared the wrong bits would reject its own address. It sends all-ones and all-zero payloads together with a data MSB of 1, so that a split of byte 1 shifted by one bit shows up as a wrong `wr_addr` or `wr_data`. It also cuts transfers short with a stop and with a start after the first payload byte. A design that restarted on the early start, or that wrote on the stop, would acknowledge the next address or produce a write the scoreboard does not expect.

// File: rtl/ctl2w_write_slave.sv
module ctl2w_write_slave #(
  parameter int SYNC_LEN = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [6:0] dev_addr,
  output logic       sda_pull,
  output logic       wr_en,
  output logic [6:0] wr_addr,
  output logic [8:0] wr_data
);
  localparam int SL = (SYNC_LEN < 2) ? 2 : SYNC_LEN;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_ACKA, S_B1, S_ACK1, S_B2, S_ACK2} st_t;

  st_t         st;
  logic [SL-1:0] scl_sy, sda_sy;
  logic        scl_q, sda_q;
  logic [7:0]  sh, b1;
  logic [3:0]  cnt;

  wire scl_s   = scl_sy[SL-1];
  wire sda_s   = sda_sy[SL-1];
  wire start_c = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_c  = scl_s & scl_q & ~sda_q & sda_s;
  wire rise    = scl_s & ~scl_q;
  wire fall    = ~scl_s & scl_q;
  wire done8   = fall & (cnt == 4'd8);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= '1;
      sda_sy <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[SL-2:0], scl_i};
      sda_sy <= {sda_sy[SL-2:0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      sh       <= '0;
      b1       <= '0;
      cnt      <= '0;
      sda_pull <= 1'b0;
      wr_en    <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_c) begin
        sda_pull <= 1'b0;
        cnt      <= '0;
        st       <= (st == S_IDLE) ? S_ADDR : S_IDLE;
      end else if (stop_c) begin
        sda_pull <= 1'b0;
        st       <= S_IDLE;
      end else begin
        case (st)
          S_ADDR, S_B1, S_B2: begin
            if (rise) begin
              sh  <= {sh[6:0], sda_s};
              cnt <= cnt + 4'd1;
            end else if (done8) begin
              cnt <= '0;
              if (st == S_ADDR) begin
                if (sh == {dev_addr, 1'b0}) begin
                  sda_pull <= 1'b1;
                  st       <= S_ACKA;
                end else begin
                  st <= S_IDLE;
                end
              end else if (st == S_B1) begin
                b1       <= sh;
                sda_pull <= 1'b1;
                st       <= S_ACK1;
              end else begin
                sda_pull <= 1'b1;
                st       <= S_ACK2;
              end
            end
          end
          S_ACKA: if (fall) begin sda_pull <= 1'b0; st <= S_B1; end
          S_ACK1: if (fall) begin sda_pull <= 1'b0; st <= S_B2; end
          S_ACK2: if (fall) begin
            sda_pull <= 1'b0;
            st       <= S_IDLE;
            wr_en    <= 1'b1;
            wr_addr  <= b1[7:1];
            wr_data  <= {b1[0], sh};
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

module ctl2w_write_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_i,
  input logic sda_pull,
  input logic wr_en
);
  always @(posedge clk)
    if (!rst_n) a_r1_reset_quiet: assert (!sda_pull && !wr_en);

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);

  a_r7_write_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (!sda_pull && $past(sda_pull)));

  a_r3_pull_on_low_clock: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> !scl_i);

  a_r6_release_on_low_clock: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_pull) |-> !scl_i);
endmodule

bind ctl2w_write_slave ctl2w_write_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_pull(sda_pull), .wr_en(wr_en)
);

// File: tb/ctl2w_write_slave_bench.sv
module ctl2w_write_slave_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       sda_m = 1'b1;
  logic [6:0] dev_addr = 7'h1A;
  logic       sda_pull, wr_en;
  logic [6:0] wr_addr;
  logic [8:0] wr_data;
  wire        sda_line = sda_m & ~sda_pull;

  int tests = 0;
  int fails = 0;
  logic [15:0] exp_q[$];

  localparam int Q = 6;

  always #2 clk = ~clk;

  ctl2w_write_slave u_ctl2w_write_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .dev_addr(dev_addr), .sda_pull(sda_pull), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl = 1'b1; wq(Q);
    sda_m = 1'b0; wq(Q);
    scl = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(Q);
    scl = 1'b1; wq(Q);
    sda_m = 1'b1; wq(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(Q);
      scl = 1'b1; wq(Q);
      scl = 1'b0; wq(Q);
    end
    sda_m = 1'b1; wq(Q);
    scl = 1'b1; wq(Q/2);
    @(negedge clk) ack = ~sda_line;
    wq(Q/2);
    scl = 1'b0; wq(Q);
  endtask

  task automatic write_word(input string req, input logic [6:0] dev, input logic rw,
                            input logic [6:0] ra, input logic [8:0] d, input logic good);
    logic a;
    if (good) exp_q.push_back({ra, d});
    bus_start();
    send_byte({dev, rw}, a);   chk({req, " addr ack"}, a, good);
    send_byte({ra, d[8]}, a);  chk({req, " byte1 ack"}, a, good);
    send_byte(d[7:0], a);      chk({req, " byte2 ack"}, a, good);
    wq(4);
    chk({req, " write issued before stop"}, exp_q.size(), 0);
    bus_stop();
  endtask

  always @(negedge clk) begin
    if (rst_n && wr_en) begin
      tests++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R7 unexpected write actual=%0h expected=none", {wr_addr, wr_data});
      end else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        if ({wr_addr, wr_data} !== e) begin
          fails++;
          $display("FAIL R7 write word actual=%0h expected=%0h", {wr_addr, wr_data}, e);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic a;
    wq(3);
    @(negedge clk);
    chk("R1 pull in reset", sda_pull, 0);
    chk("R1 wr_en in reset", wr_en, 0);
    rst_n = 1'b1;
    wq(5);

    write_word("R2 R3 R6 R7 basic", 7'h1A, 1'b0, 7'h2B, 9'h155, 1'b1);
    write_word("R7 all-ones", 7'h1A, 1'b0, 7'h7F, 9'h100, 1'b1);
    write_word("R7 zeros", 7'h1A, 1'b0, 7'h00, 9'h0FF, 1'b1);
    write_word("R4 mismatch", 7'h1B, 1'b0, 7'h11, 9'h022, 1'b0);
    write_word("R5 read", 7'h1A, 1'b1, 7'h11, 9'h022, 1'b0);

    // R8: stop after the first payload byte
    bus_start();
    send_byte({7'h1A, 1'b0}, a); chk("R8 stop-abort addr ack", a, 1);
    send_byte(8'h81, a);         chk("R8 stop-abort byte1 ack", a, 1);
    bus_stop();
    wq(10);

    // R8: start after the first payload byte, then an address byte
    bus_start();
    send_byte({7'h1A, 1'b0}, a); chk("R8 start-abort addr ack", a, 1);
    send_byte(8'h42, a);         chk("R8 start-abort byte1 ack", a, 1);
    bus_start();
    send_byte({7'h1A, 1'b0}, a); chk("R8 no ack after mid start", a, 0);
    bus_stop();
    wq(10);

    write_word("R9 after aborts", 7'h1A, 1'b0, 7'h05, 9'h1A5, 1'b1);
    dev_addr = 7'h55;
    write_word("R9 old address", 7'h1A, 1'b0, 7'h05, 9'h001, 1'b0);
    write_word("R9 new address", 7'h55, 1'b0, 7'h3C, 9'h0C3, 1'b1);

    wq(20);
    chk("R7 R8 scoreboard drained", exp_q.size(), 0);
    chk("R6 pull released at end", sda_pull, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule